// File: doc/BRIEF.md
# Dual Wiper Command Decoder

This block interprets the command stream that controls two digitally stepped wipers. An SPI front end delivers whole received bytes with a one-cycle valid strobe, a one-cycle strobe for each serial clock pulse (carrying the serial input bit), and the chip-select level. All of these are already synchronous to the block clock. A frame starts with an address byte. The block accepts the frame only if the address byte carries the fixed device identifier and matches the sub-address set on the strap pins. The second byte picks one of ten operations. These read or write a wiper register, read or write one of the four data registers behind each wiper, copy values between a wiper and its data registers (for one wiper or for both at once), return the write-busy status, or enter a streaming step mode.

Each wiper register is six bits wide and is a plain output. The eight data registers (four per wiper) are held in flops. Any change to a data register is reported to a downstream nonvolatile write sequencer with a single pulse once the frame closes. The byte to be shifted out is presented on a registered read port.

Top module: `wiper_cmd_decoder`

## Requirements
- R1: A frame is acted on only when its first byte has bits 7:4 = 0101, bits 3:2 = 00 and bits 1:0 equal to `strap_addr`. Otherwise every later byte and step pulse of that frame leaves the wipers, the data registers and `rd_byte` unchanged.
- R2: The second byte is decoded with the opcode in bits 7:4, the data-register index in bits 3:2 and the wiper index in bit 0. Bit 1 is not used.
- R3: Opcode 1001 (read wiper) places the selected wiper value in `rd_byte` bits 5:0, with bits 7:6 zero, one cycle after the instruction byte strobe. `rd_byte` then holds that value for the rest of the frame.
- R4: Opcode 1010 (write wiper) loads bits 5:0 of the third byte into the selected wiper one cycle after that byte's strobe. Bits 7:6 are ignored.
- R5: Opcode 1011 (read data register) returns the register chosen by wiper index and data-register index, in the same way as R3. Opcode 1100 (write data register) stores bits 5:0 of the third byte into that register.
- R6: Opcode 1101 copies the chosen data register into its own wiper. Opcode 1110 copies the chosen wiper into the chosen data register. Both act on the instruction byte itself.
- R7: Opcode 0001 copies data register [index] of each wiper into that wiper. Opcode 1000 copies each wiper into its own data register [index]. Both wipers are handled on the same clock edge.
- R8: After opcode 0010, each step strobe moves the selected wiper up by one if `step_dir` is 1, or down by one if it is 0. The value stops at 63 going up and at 0 going down. Stepping continues until `cs_n` rises.
- R9: When a frame has changed a data register (opcode 1100, 1110 or 1000), `nvw_req` is high for exactly one cycle, on the cycle after `cs_n` is first seen high. Frames that change no data register, including wiper writes, produce no pulse.
- R10: Opcode 0101 returns `{7'b0, nvw_busy}` in `rd_byte` one cycle after the instruction byte.
- R11: While reset is asserted and after it is released, wiper 0 and wiper 1 equal the reset contents of their data register 0, `rd_byte` is 0 and `nvw_req` is 0.
- R12: Any opcode other than the ten listed makes the rest of the frame a no-op.
- R13: Bytes received after a command has completed are ignored. For the four copy commands, completion is the instruction byte. For the other three-byte commands, it is the third byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select level, low during a frame |
| byte_vld | input | 1 | One-cycle strobe: a whole byte was received |
| byte_data | input | 8 | Received byte, valid with `byte_vld` |
| step_vld | input | 1 | One-cycle strobe per serial clock pulse |
| step_dir | input | 1 | Serial input bit sampled with `step_vld` |
| strap_addr | input | 2 | Pin-strapped sub-address |
| nvw_busy | input | 1 | Busy flag from the nonvolatile write sequencer |
| rd_byte | output | 8 | Byte presented to the output shifter |
| nvw_req | output | 1 | One-cycle request to commit data registers |
| wiper0 | output | 6 | Wiper 0 position |
| wiper1 | output | 6 | Wiper 1 position |

## Verification
Every result is registered once. Wiper, data-register and `rd_byte` changes are due one clock after the strobe that causes them. `nvw_req` is due one clock after the first cycle in which `cs_n` is high, and must be low again one clock later. The bench drives each strobe for one cycle on a falling edge and samples on the next falling edge, so each sample falls exactly one rising edge after its stimulus. It compares against a reference model of the register file that the bench updates as it issues each byte.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_INSTR,
        ST_DATA,
        ST_STEP,
        ST_SKIP
    } wcd_state_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_WIP,
        OP_WR_WIP,
        OP_RD_REG,
        OP_WR_REG,
        OP_REG2WIP,
        OP_WIP2REG,
        OP_ALL_REG2WIP,
        OP_ALL_WIP2REG,
        OP_STEP,
        OP_STATUS
    } wcd_op_e;

endpackage

// File: rtl/wcd_addr_match.sv
module wcd_addr_match #(
    parameter logic [3:0] DEV_ID = 4'b0101
) (
    input  logic [7:0] addr_byte,
    input  logic [1:0] strap,
    output logic       hit
);
    always_comb begin
        hit = (addr_byte[7:4] == DEV_ID) &&
              (addr_byte[3:2] == 2'b00) &&
              (addr_byte[1:0] == strap);
    end
endmodule

// File: rtl/wcd_op_decode.sv
module wcd_op_decode
    import wcd_pkg::*;
(
    input  logic [3:0] opc,
    output wcd_op_e    op
);
    always_comb begin
        unique case (opc)
            4'b1001: op = OP_RD_WIP;
            4'b1010: op = OP_WR_WIP;
            4'b1011: op = OP_RD_REG;
            4'b1100: op = OP_WR_REG;
            4'b1101: op = OP_REG2WIP;
            4'b1110: op = OP_WIP2REG;
            4'b0001: op = OP_ALL_REG2WIP;
            4'b1000: op = OP_ALL_WIP2REG;
            4'b0010: op = OP_STEP;
            4'b0101: op = OP_STATUS;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/wcd_wiper_step.sv
module wcd_wiper_step #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    always_comb begin
        if (up) begin
            nxt = (cur == TOP) ? cur : cur + W'(1);
        end else begin
            nxt = (cur == BOT) ? cur : cur - W'(1);
        end
    end
endmodule

// File: rtl/wiper_cmd_decoder.sv
module wiper_cmd_decoder
    import wcd_pkg::*;
#(
    parameter int         WIPER_W = 6,
    parameter logic [3:0] DEV_ID  = 4'b0101,
    parameter logic [5:0] W0_INIT = 6'd32,
    parameter logic [5:0] W1_INIT = 6'd16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       step_vld,
    input  logic       step_dir,
    input  logic [1:0] strap_addr,
    input  logic       nvw_busy,
    output logic [7:0] rd_byte,
    output logic       nvw_req,
    output logic [5:0] wiper0,
    output logic [5:0] wiper1
);
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int NDR    = 1 << SEL_W;
    localparam int NW     = 2;

    typedef struct packed {
        wcd_state_e                             st;
        wcd_op_e                                op;
        logic [SEL_W-1:0]                       rsel;
        logic                                   psel;
        logic [NW-1:0][WIPER_W-1:0]             wip;
        logic [NW-1:0][NDR-1:0][WIPER_W-1:0]    dr;
        logic [BYTE_W-1:0]                      rd;
        logic                                   pend;
        logic                                   nvw;
    } regs_t;

    regs_t   q, d;
    logic    addr_hit;
    wcd_op_e dec_op;
    logic [NW-1:0][WIPER_W-1:0] stepped;
    logic    step_mode;

    wcd_addr_match #(.DEV_ID(DEV_ID)) u_addr (
        .addr_byte (byte_data),
        .strap     (strap_addr),
        .hit       (addr_hit)
    );

    wcd_op_decode u_dec (
        .opc (byte_data[7:4]),
        .op  (dec_op)
    );

    for (genvar k = 0; k < NW; k++) begin : g_step
        wcd_wiper_step #(.W(WIPER_W)) u_step (
            .cur (q.wip[k]),
            .up  (step_dir),
            .nxt (stepped[k])
        );
    end

    function automatic regs_t reset_value();
        regs_t r;
        r       = '0;
        r.st    = ST_ADDR;
        r.op    = OP_NONE;
        r.dr[0][0] = WIPER_W'(W0_INIT);
        r.dr[1][0] = WIPER_W'(W1_INIT);
        r.wip[0]   = WIPER_W'(W0_INIT);
        r.wip[1]   = WIPER_W'(W1_INIT);
        return r;
    endfunction

    always_comb begin
        logic [SEL_W-1:0] rs;
        logic             ps;
        d     = q;
        d.nvw = 1'b0;
        rs    = byte_data[3:2];
        ps    = byte_data[0];
        if (cs_n) begin
            d.st = ST_ADDR;
            if (q.pend) begin
                d.nvw  = 1'b1;
                d.pend = 1'b0;
            end
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (byte_vld) begin
                        d.st = addr_hit ? ST_INSTR : ST_SKIP;
                    end
                end
                ST_INSTR: begin
                    if (byte_vld) begin
                        d.op   = dec_op;
                        d.rsel = rs;
                        d.psel = ps;
                        d.st   = ST_SKIP;
                        unique case (dec_op)
                            OP_RD_WIP: begin
                                d.rd = '0;
                                d.rd[WIPER_W-1:0] = q.wip[ps];
                                d.st = ST_DATA;
                            end
                            OP_RD_REG: begin
                                d.rd = '0;
                                d.rd[WIPER_W-1:0] = q.dr[ps][rs];
                                d.st = ST_DATA;
                            end
                            OP_STATUS: begin
                                d.rd = '0;
                                d.rd[0] = nvw_busy;
                                d.st = ST_DATA;
                            end
                            OP_WR_WIP, OP_WR_REG: begin
                                d.st = ST_DATA;
                            end
                            OP_REG2WIP: begin
                                d.wip[ps] = q.dr[ps][rs];
                            end
                            OP_WIP2REG: begin
                                d.dr[ps][rs] = q.wip[ps];
                                d.pend       = 1'b1;
                            end
                            OP_ALL_REG2WIP: begin
                                for (int k = 0; k < NW; k++) begin
                                    d.wip[k] = q.dr[k][rs];
                                end
                            end
                            OP_ALL_WIP2REG: begin
                                for (int k = 0; k < NW; k++) begin
                                    d.dr[k][rs] = q.wip[k];
                                end
                                d.pend = 1'b1;
                            end
                            OP_STEP: begin
                                d.st = ST_STEP;
                            end
                            default: begin
                                d.st = ST_SKIP;
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    if (byte_vld) begin
                        d.st = ST_SKIP;
                        if (q.op == OP_WR_WIP) begin
                            d.wip[q.psel] = byte_data[WIPER_W-1:0];
                        end else if (q.op == OP_WR_REG) begin
                            d.dr[q.psel][q.rsel] = byte_data[WIPER_W-1:0];
                            d.pend               = 1'b1;
                        end
                    end
                end
                ST_STEP: begin
                    if (step_vld) begin
                        d.wip[q.psel] = stepped[q.psel];
                    end
                end
                default: begin
                    d.st = ST_SKIP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= reset_value();
        end else begin
            q <= d;
        end
    end

    assign step_mode = (q.st == ST_STEP);
    assign rd_byte   = q.rd;
    assign nvw_req   = q.nvw;
    assign wiper0    = 6'(q.wip[0]);
    assign wiper1    = 6'(q.wip[1]);

endmodule

// File: rtl/wcd_checker.sv
module wcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       step_mode,
    input logic [7:0] rd_byte,
    input logic       nvw_req,
    input logic [5:0] wiper0,
    input logic [5:0] wiper1
);
    assert_nvw_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nvw_req |=> !nvw_req);

    assert_nvw_after_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nvw_req |-> $past(cs_n));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(wiper0) && $stable(wiper1)));

    assert_rd_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte[7:1] == 7'd0 || rd_byte[7:6] == 2'b00);

    assert_step_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_mode |=> (wiper0 == $past(wiper0) ||
                       wiper0 == $past(wiper0) + 6'd1 ||
                       wiper0 == $past(wiper0) - 6'd1));

    assert_step_no_wrap_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode && wiper1 == 6'd63) |=> wiper1 != 6'd0);

    assert_step_no_wrap_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode && wiper1 == 6'd0) |=> wiper1 != 6'd63);
endmodule

bind wiper_cmd_decoder wcd_checker u_wcd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .step_mode (step_mode),
    .rd_byte   (rd_byte),
    .nvw_req   (nvw_req),
    .wiper0    (wiper0),
    .wiper1    (wiper1)
);

// File: tb/tb_wiper_cmd_decoder.sv
module tb_wiper_cmd_decoder;
    localparam logic [5:0] INIT0 = 6'd40;
    localparam logic [5:0] INIT1 = 6'd5;
    localparam logic [1:0] STRAP = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       step_vld = 1'b0;
    logic       step_dir = 1'b0;
    logic [1:0] strap_addr = STRAP;
    logic       nvw_busy = 1'b0;
    logic [7:0] rd_byte;
    logic       nvw_req;
    logic [5:0] wiper0, wiper1;

    int n_chk = 0;
    int n_bad = 0;

    logic [5:0] m_w [2];
    logic [5:0] m_dr [2][4];
    logic [7:0] m_rd;

    always #2 clk = ~clk;

    wiper_cmd_decoder #(
        .W0_INIT (INIT0),
        .W1_INIT (INIT1)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n),
        .byte_vld (byte_vld), .byte_data (byte_data),
        .step_vld (step_vld), .step_dir (step_dir),
        .strap_addr (strap_addr), .nvw_busy (nvw_busy),
        .rd_byte (rd_byte), .nvw_req (nvw_req),
        .wiper0 (wiper0), .wiper1 (wiper1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    function automatic logic [5:0] sat(input logic [5:0] v, input logic up);
        if (up) return (v == 6'd63) ? v : v + 6'd1;
        return (v == 6'd0) ? v : v - 6'd1;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic send_step(input logic dir);
        @(negedge clk);
        step_vld = 1'b1;
        step_dir = dir;
        @(negedge clk);
        step_vld = 1'b0;
    endtask

    // op codes: 1 rdw 2 wrw 3 rdreg 4 wrreg 5 reg2w 6 w2reg 7 gReg2w 8 gW2reg 9 step 10 status 0 none
    function automatic int op_of(input logic [3:0] n);
        case (n)
            4'b1001: return 1;  4'b1010: return 2;
            4'b1011: return 3;  4'b1100: return 4;
            4'b1101: return 5;  4'b1110: return 6;
            4'b0001: return 7;  4'b1000: return 8;
            4'b0010: return 9;  4'b0101: return 10;
            default: return 0;
        endcase
    endfunction

    task automatic do_frame(input logic [7:0] a, input logic [7:0] ins,
                            input logic [7:0] dat, input int nsteps,
                            input logic [31:0] dirs, input logic busy);
        logic hit;
        int   op;
        logic p;
        logic [1:0] r;
        logic pend;
        hit  = (a[7:4] == 4'b0101) && (a[3:2] == 2'b00) && (a[1:0] == STRAP);
        op   = hit ? op_of(ins[7:4]) : 0;
        p    = ins[0];
        r    = ins[3:2];
        pend = 1'b0;
        @(negedge clk);
        nvw_busy = busy;
        cs_n     = 1'b0;
        send_byte(a);
        send_byte(ins);
        case (op)
            1: m_rd = {2'b00, m_w[p]};
            3: m_rd = {2'b00, m_dr[p][r]};
            10: m_rd = {7'd0, busy};
            5: m_w[p] = m_dr[p][r];
            6: begin m_dr[p][r] = m_w[p]; pend = 1'b1; end
            7: begin m_w[0] = m_dr[0][r]; m_w[1] = m_dr[1][r]; end
            8: begin m_dr[0][r] = m_w[0]; m_dr[1][r] = m_w[1]; pend = 1'b1; end
            default: ;
        endcase
        if (op == 1) chk("R3 read wiper", rd_byte, m_rd);
        else if (op == 3) chk("R5 read data reg", rd_byte, m_rd);
        else if (op == 10) chk("R10 status", rd_byte, m_rd);
        else if (op >= 5 && op <= 8) begin
            chk("R6/R7 copy wiper0", {2'b0, wiper0}, {2'b0, m_w[0]});
            chk("R6/R7 copy wiper1", {2'b0, wiper1}, {2'b0, m_w[1]});
        end
        if (op == 9) begin
            for (int i = 0; i < nsteps; i++) begin
                send_step(dirs[i]);
                m_w[p] = sat(m_w[p], dirs[i]);
                chk("R8 step", {2'b0, p ? wiper1 : wiper0}, {2'b0, m_w[p]});
            end
        end else begin
            send_byte(dat);
            if (op == 2) m_w[p] = dat[5:0];
            if (op == 4) begin m_dr[p][r] = dat[5:0]; pend = 1'b1; end
            for (int i = 0; i < nsteps; i++) send_step(dirs[i]);
            send_byte(~dat);
            chk("R1/R12/R13 rd hold", rd_byte, m_rd);
        end
        chk("R4 wiper0 end", {2'b0, wiper0}, {2'b0, m_w[0]});
        chk("R4 wiper1 end", {2'b0, wiper1}, {2'b0, m_w[1]});
        cs_n = 1'b1;
        @(negedge clk);
        chk("R9 nvw pulse", {7'd0, nvw_req}, {7'd0, pend});
        @(negedge clk);
        chk("R9 nvw single", {7'd0, nvw_req}, 8'd0);
    endtask

    function automatic logic [7:0] gud();
        return {6'b010100, STRAP};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        report();
        $finish;
    end

    initial begin
        logic [3:0] opl [10];
        void'($urandom(32'd1234));
        for (int i = 0; i < 2; i++) begin
            m_w[i] = 6'd0;
            for (int j = 0; j < 4; j++) m_dr[i][j] = 6'd0;
        end
        m_dr[0][0] = INIT0; m_dr[1][0] = INIT1;
        m_w[0] = INIT0;     m_w[1] = INIT1;
        m_rd = 8'd0;
        repeat (3) @(negedge clk);
        chk("R11 reset wiper0", {2'b0, wiper0}, {2'b0, INIT0});
        chk("R11 reset wiper1", {2'b0, wiper1}, {2'b0, INIT1});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rd after reset", rd_byte, 8'd0);
        chk("R11 nvw after reset", {7'd0, nvw_req}, 8'd0);
        chk("R11 wiper0 after reset", {2'b0, wiper0}, {2'b0, INIT0});

        // R5: data register 0 holds reset values; R2 field positions
        do_frame(gud(), 8'b1011_00_0_1, 8'h00, 0, 0, 1'b0);
        do_frame(gud(), 8'b1011_00_0_0, 8'h00, 0, 0, 1'b0);
        // R4: bits 7:6 ignored
        do_frame(gud(), 8'b1010_00_0_0, 8'hFE, 0, 0, 1'b0);
        // R8: saturation at top and bottom
        do_frame(gud(), 8'b1010_00_0_1, 8'd62, 0, 0, 1'b0);
        do_frame(gud(), 8'b0010_00_0_1, 8'h00, 3, 32'h7, 1'b0);
        do_frame(gud(), 8'b1010_00_0_0, 8'd1, 0, 0, 1'b0);
        do_frame(gud(), 8'b0010_00_0_0, 8'h00, 3, 32'h0, 1'b0);
        // R1: wrong strap, wrong ID, nonzero middle bits
        do_frame({6'b010100, ~STRAP}, 8'b1010_00_0_0, 8'd33, 2, 3, 1'b0);
        do_frame(8'b0110_0010, 8'b1100_01_0_0, 8'd9, 0, 0, 1'b0);
        do_frame({6'b010110, STRAP}, 8'b1010_00_0_1, 8'd7, 0, 0, 1'b0);
        // R12: unknown opcode
        do_frame(gud(), 8'b0011_00_0_0, 8'd17, 2, 1, 1'b0);
        // R7 / R6 / R13 / R9 / R10
        do_frame(gud(), 8'b1100_10_0_0, 8'd11, 0, 0, 1'b0);
        do_frame(gud(), 8'b1100_10_0_1, 8'd22, 0, 0, 1'b0);
        do_frame(gud(), 8'b0001_10_0_0, 8'h55, 0, 0, 1'b0);
        do_frame(gud(), 8'b1000_11_0_0, 8'h12, 0, 0, 1'b0);
        do_frame(gud(), 8'b1011_11_0_1, 8'h00, 0, 0, 1'b0);
        do_frame(gud(), 8'b0101_00_0_0, 8'h00, 0, 0, 1'b1);
        do_frame(gud(), 8'b0101_00_0_0, 8'h00, 0, 0, 1'b0);

        opl = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101,
                4'b1110, 4'b0001, 4'b1000, 4'b0010, 4'b0101};
        for (int f = 0; f < 300; f++) begin
            logic [7:0] a;
            logic [7:0] ins;
            logic [3:0] oc;
            if (($urandom % 8) == 0) a = 8'($urandom);
            else a = gud();
            if (($urandom % 10) == 0) oc = 4'($urandom);
            else oc = opl[$urandom % 10];
            ins = {oc, 2'($urandom), 1'b0, 1'($urandom)};
            do_frame(a, ins, 8'($urandom), int'($urandom % 6),
                     $urandom, 1'($urandom));
        end
        report();
        $finish;
    end
endmodule